// File: doc/BRIEF.md
# Sixteen-bit two-level lookahead adder

This block adds two 16-bit unsigned (or two's-complement) operands and a carry input in pure combinational logic. The operands are split into four 4-bit groups. Each group forms per-bit generate and propagate terms and resolves its internal carries with fully expanded sum-of-products equations. A second lookahead level takes the four group generate/propagate pairs and the carry input, and produces the carry into every group at once. No carry ripples from one group to the next.

The block also reports a block-wide generate and propagate pair. A wider adder can therefore feed these into a further lookahead level. The bit-level propagate is the inclusive OR of the operand bits. The sum bits use the exclusive OR of the operands and the incoming carry.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals (a + b + cin) modulo 2^16 for every input combination.
- R2: `cout` equals bit 16 of the 17-bit value a + b + cin.
- R3: A carry input of 1 with a = 16'hFFFF and b = 16'h0000 travels through all four groups: `sum` is 16'h0000 and `cout` is 1.
- R4: `blk_p` is 1 exactly when every bit position has a or b set, using OR propagate. For example, a = b = 16'hFFFF gives `blk_p` = 1.
- R5: `blk_g` is 1 exactly when a + b alone is at least 2^16, whatever the value of `cin`.
- R6: `cout` equals `blk_g` OR (`blk_p` AND `cin`), so the block can sit under a further lookahead level.
- R7: The carry out of each lower group reaches the next group's low bit. For example, 16'h000F + 1 gives 16'h0010, 16'h00FF + 1 gives 16'h0100, and 16'h0FFF + 1 gives 16'h1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |
| blk_p | output | 1 | Block propagate: every bit propagates |
| blk_g | output | 1 | Block generate: a carry is produced without cin |

## Verification
The embedded assertions check two things whenever the inputs settle. First, every lookahead carry must match the single-step recurrence built from the carry below it, at both levels. Second, the group and block results must equal the arithmetic sum, and the cascade relation between `cout`, `blk_g` and `blk_p` must hold. Some behaviours show up only through the bench's chosen operands, and only at the ports: a carry running the full width, carries crossing each group boundary, and the OR-based propagate when both operand bits are 1. The random sweep then covers the general sum, carry and block-flag behaviour.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Default partitioning of the adder
  localparam int CLA_GROUP_W    = 4;
  localparam int CLA_NUM_GROUPS = 4;
endpackage

// File: rtl/cla_lookahead.sv
// Lookahead unit: expands every carry as a flat sum of products over
// generate/propagate inputs; reused at bit level and at group level.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N:0]   carry_o,
  output logic         grp_g,
  output logic         grp_p
);

  // carry into position k, fully expanded (no chained terms)
  function automatic logic expand_carry(input logic [N-1:0] gv,
                                        input logic [N-1:0] pv,
                                        input logic         ci,
                                        input int           k,
                                        input logic         use_ci);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < k; j++) begin
      term = gv[j];
      for (int m = j + 1; m < k; m++) term = term & pv[m];
      acc = acc | term;
    end
    term = use_ci & ci;
    for (int m = 0; m < k; m++) term = term & pv[m];
    return acc | term;
  endfunction

  assign carry_o[0] = cin;

  for (genvar k = 1; k <= N; k++) begin : g_carry
    assign carry_o[k] = expand_carry(gen_i, prop_i, cin, k, 1'b1);
  end

  assign grp_g = expand_carry(gen_i, prop_i, 1'b0, N, 1'b0);
  assign grp_p = &prop_i;

  // R7: each expanded carry agrees with the one-step recurrence
  for (genvar k = 1; k <= N; k++) begin : g_chk
    always_comb begin
      // R7
      carry_recur_chk: assert (carry_o[k] == (gen_i[k-1] | (prop_i[k-1] & carry_o[k-1])))
        else $error("lookahead carry %0d disagrees with recurrence", k);
    end
  end

  always_comb begin
    // R6
    grp_cascade_chk: assert (carry_o[N] == (grp_g | (grp_p & cin)))
      else $error("group carry-out disagrees with group G/P");
  end

endmodule

// File: rtl/cla_group.sv
// One W-bit adder group: bit-level generate/propagate, local lookahead,
// sum bits and group G/P. Carry-in comes from the upper lookahead level.
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         grp_g,
  output logic         grp_p
);

  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W:0]   bit_c;

  assign bit_g = a & b;
  assign bit_p = a | b;

  cla_lookahead #(.N(W)) u_look (
    .gen_i   (bit_g),
    .prop_i  (bit_p),
    .cin     (cin),
    .carry_o (bit_c),
    .grp_g   (grp_g),
    .grp_p   (grp_p)
  );

  assign sum = a ^ b ^ bit_c[W-1:0];

  always_comb begin
    // R4
    gen_in_prop_chk: assert ((bit_g & ~bit_p) == '0)
      else $error("generate set without propagate");
    // R1
    grp_sum_chk: assert (sum == W'({1'b0, a} + {1'b0, b} + (W+1)'(cin)))
      else $error("group sum mismatch");
  end

endmodule

// File: rtl/cla_adder16.sv
// Two-level lookahead adder: NUM_GROUPS groups of GROUP_W bits, with a
// second lookahead level supplying every group carry-in.
module cla_adder16
  import cla_pkg::*;
#(
  parameter int GROUP_W    = CLA_GROUP_W,
  parameter int NUM_GROUPS = CLA_NUM_GROUPS,
  localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             blk_p,
  output logic             blk_g
);

  logic [NUM_GROUPS-1:0] grp_g;
  logic [NUM_GROUPS-1:0] grp_p;
  logic [NUM_GROUPS:0]   grp_c;

  for (genvar i = 0; i < NUM_GROUPS; i++) begin : g_grp
    cla_group #(.W(GROUP_W)) u_grp (
      .a     (a[i*GROUP_W +: GROUP_W]),
      .b     (b[i*GROUP_W +: GROUP_W]),
      .cin   (grp_c[i]),
      .sum   (sum[i*GROUP_W +: GROUP_W]),
      .grp_g (grp_g[i]),
      .grp_p (grp_p[i])
    );
  end

  cla_lookahead #(.N(NUM_GROUPS)) u_top_look (
    .gen_i   (grp_g),
    .prop_i  (grp_p),
    .cin     (cin),
    .carry_o (grp_c),
    .grp_g   (blk_g),
    .grp_p   (blk_p)
  );

  assign cout = grp_c[NUM_GROUPS];

  always_comb begin
    // R1 R2
    full_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)))
      else $error("adder result mismatch");
    // R6
    blk_cascade_chk: assert (cout == (blk_g | (blk_p & cin)))
      else $error("block carry-out disagrees with block G/P");
  end

endmodule

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic [15:0] sum;
    logic        cout;
    logic        bp;
    logic        bg;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    '{16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0},  // R3
    '{16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1},
    '{16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, 1'b0, 1'b0},  // R7
    '{16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0, 1'b0, 1'b0},  // R7
    '{16'h0FFF, 16'h0001, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},  // R7
    '{16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b1},  // R4 OR-propagate
    '{16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1},
    '{16'h7FFF, 16'h8000, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0},
    '{16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, 1'b0, 1'b0}
  };

  logic clk;
  logic rst_n;
  logic [15:0] a, b, sum;
  logic cin, cout, blk_p, blk_g;
  int checks;
  int errors;
  bit done;

  cla_adder16 u_dut (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .blk_p (blk_p),
    .blk_g (blk_g)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d actual=%h expected=%h", tag, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc);
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #2;
  endtask

  task automatic check_all();
    logic [16:0] tot;
    logic [16:0] nocin;
    tot   = {1'b0, a} + {1'b0, b} + 17'(cin);
    nocin = {1'b0, a} + {1'b0, b};
    chk("R1 sum", int'(sum), int'(tot[15:0]));
    chk("R2 cout", int'(cout), int'(tot[16]));
    chk("R4 blk_p", int'(blk_p), int'(&(a | b)));
    chk("R5 blk_g", int'(blk_g), int'(nocin[16]));
    chk("R6 cascade", int'(cout), int'(blk_g | (blk_p & cin)));
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // idle state after reset: zero operands give zero outputs (R1 R2)
    apply(16'h0000, 16'h0000, 1'b0);
    chk("R1 idle sum", int'(sum), 0);
    chk("R2 idle cout", int'(cout), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].cin);
      chk("R1 table sum", int'(sum), int'(VECS[i].sum));
      chk("R2 table cout", int'(cout), int'(VECS[i].cout));
      chk("R4 table blk_p", int'(blk_p), int'(VECS[i].bp));
      chk("R5 table blk_g", int'(blk_g), int'(VECS[i].bg));
    end

    // R3: full-width carry travel, directed
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R3 sum", int'(sum), 0);
    chk("R3 cout", int'(cout), 1);

    // R7: carry into each group boundary from cin alone
    for (int g = 1; g < 4; g++) begin
      apply(16'((1 << (4 * g)) - 1), 16'h0000, 1'b1);
      chk("R7 boundary", int'(sum), 1 << (4 * g));
    end

    // R5: blk_g does not depend on cin
    apply(16'hF000, 16'h1000, 1'b0);
    chk("R5 cin0", int'(blk_g), 1);
    apply(16'hF000, 16'h1000, 1'b1);
    chk("R5 cin1", int'(blk_g), 1);

    // random sweep
    for (int i = 0; i < 300; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      check_all();
    end

    // propagate-heavy patterns: complementary operands
    for (int i = 0; i < 50; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      apply(r, ~r, 1'($urandom));
      check_all();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule